// File: doc/BRIEF.md
# Clock-Enable Integer Up Sampler

This block raises the sample rate of a data stream by a fixed integer factor inside a design where every register shares one fast clock and rate is expressed through enable pulses. A slow enable marks the cycles on which a new input sample is presented. A fast enable, pulsing `FACTOR` times as often, marks the cycles on which one output slot is issued. Each input sample therefore spans a frame of `FACTOR` output slots. The first slot of a frame is the head slot. The remaining slots are fill slots.

A mode input selects how the fill slots are filled. In replicate mode (`zero_fill = 0`) the held sample is repeated, so the output is a plain copy of the held value. In zero-fill mode (`zero_fill = 1`) a two-way multiplexer places zero in every fill slot, and only the head slot carries the sample. Frame position is tracked by a two-state machine with a slot counter. State `ST_HEAD` means the next fast slot is a head slot. State `ST_FILL` means the next slot is a fill slot whose index is held in the counter. The machine has four transitions:
- START: a head slot is issued, moving `ST_HEAD` to `ST_FILL` with the counter at 1.
- STEP: a fill slot before the last is issued, staying in `ST_FILL` and incrementing the counter.
- WRAP: the last fill slot is issued, returning to `ST_HEAD`.
- REALIGN: a slow enable forces the current or next slot to be a head slot.

Outputs are registered. They appear one clock after the enabling edge.

Top module: `upsamp_ce`

## Requirements
- R1: Each cycle with `fast_ce` high is followed by exactly one cycle with `out_valid` high. A cycle with `fast_ce` low is followed by `out_valid` low.
- R2: In replicate mode (`zero_fill` = 0), every issued slot, head or fill, outputs the currently held sample.
- R3: In zero-fill mode (`zero_fill` = 1), every fill slot outputs 0, and every head slot outputs the held sample.
- R4: After a head slot, the next `FACTOR`-1 fast slots are fill slots. The slot after those is a head slot again, even when no new slow enable has arrived. `FACTOR` must be at least 2.
- R5: When `slow_ce` and `fast_ce` are both high in one cycle, that slot is a head slot and carries the `din` of that same cycle. This holds at any frame position.
- R6: A `slow_ce` with `fast_ce` low captures `din` as the held sample and makes the next fast slot a head slot, without issuing an output.
- R7: `head_flag` is high exactly on output cycles that issue a head slot, in both modes.
- R8: In a cycle following `fast_ce` low, `dout` keeps its previous value and `head_flag` is low.
- R9: After reset, `dout`, `out_valid` and `head_flag` are 0, the held sample is 0, and the first fast slot is a head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | Input-rate enable; `din` is taken when high |
| fast_ce | input | 1 | Output-rate enable; one slot issued per pulse |
| zero_fill | input | 1 | 0 = replicate held sample, 1 = zeros in fill slots |
| din | input | DATA_W | Input sample |
| dout | output | DATA_W | Output sample, registered |
| out_valid | output | 1 | One-cycle pulse per issued slot |
| head_flag | output | 1 | Marks the slot carrying the sample (head slot) |

## Verification
The hardest situation to reach from the ports is a slow enable arriving at a frame position other than the head. It can arrive either mid-frame, together with a fast pulse, or on its own between fast pulses. Either way the machine must realign without dropping or doubling a head slot. The stimulus table therefore injects a slow enable one slot early, in zero-fill mode, where a misplaced head shows up as a zero where a sample is expected. A directed sequence then issues a lone slow enable and checks the following fast slot. Another directed run leaves the slow enable silent for two whole frames, which shows the wrap back to `ST_HEAD` without any new input.

// File: rtl/upsamp_pkg.sv
package upsamp_pkg;
    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_FILL = 1'b1
    } frame_state_t;
endpackage

// File: rtl/upsamp_phase.sv
module upsamp_phase
    import upsamp_pkg::*;
#(
    parameter int FACTOR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_ce,
    input  logic fast_ce,
    output logic head_slot
);
    localparam int CNT_W = (FACTOR > 2) ? $clog2(FACTOR) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FACTOR - 1);

    frame_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    initial begin
        a_r4_factor_min: assert (FACTOR >= 2);
    end

    // Slow enable forces a head slot (REALIGN)
    assign head_slot = slow_ce || (state_q == ST_HEAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fast_ce) begin
            if (head_slot) begin
                state_d = ST_FILL;            // START
                cnt_d   = CNT_W'(1);
            end else begin
                unique case (state_q)
                    ST_FILL: begin
                        if (cnt_q == LAST_IDX) begin
                            state_d = ST_HEAD; // WRAP
                            cnt_d   = '0;
                        end else begin
                            cnt_d   = cnt_q + CNT_W'(1); // STEP
                        end
                    end
                    default: begin
                        state_d = ST_HEAD;
                        cnt_d   = '0;
                    end
                endcase
            end
        end else if (slow_ce) begin
            state_d = ST_HEAD;                // REALIGN without a slot
            cnt_d   = '0;
        end
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (cnt_q >= CNT_W'(1) && cnt_q <= LAST_IDX));
    a_r4_wrap_to_head: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ce && !slow_ce && state_q == ST_FILL && cnt_q == LAST_IDX) |=> (state_q == ST_HEAD));
    a_r6_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_ce && !fast_ce) |=> (state_q == ST_HEAD));
endmodule

// File: rtl/upsamp_hold.sv
module upsamp_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_ce,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (slow_ce) held <= din;
    end

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_ce |=> $stable(held));
endmodule

// File: rtl/upsamp_outmux.sv
module upsamp_outmux #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_ce,
    input  logic              zero_fill,
    input  logic              head_slot,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid,
    output logic              head_flag
);
    logic [DATA_W-1:0] slot_val;

    // Two-way select: sample or constant zero
    assign slot_val = (zero_fill && !head_slot) ? '0 : sample;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
            head_flag <= 1'b0;
        end else begin
            out_valid <= fast_ce;
            head_flag <= fast_ce && head_slot;
            if (fast_ce) dout <= slot_val;
        end
    end

    a_r8_hold_dout: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_ce |=> ($stable(dout) && !head_flag));
endmodule

// File: rtl/upsamp_ce.sv
module upsamp_ce #(
    parameter int DATA_W = 16,
    parameter int FACTOR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_ce,
    input  logic              fast_ce,
    input  logic              zero_fill,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid,
    output logic              head_flag
);
    logic              head_slot;
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] sample;

    upsamp_phase #(.FACTOR(FACTOR)) u_phase (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
        .fast_ce(fast_ce), .head_slot(head_slot)
    );

    upsamp_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
        .din(din), .held(held)
    );

    // New sample bypasses the hold register on its arrival cycle
    assign sample = slow_ce ? din : held;

    upsamp_outmux #(.DATA_W(DATA_W)) u_outmux (
        .clk(clk), .rst_n(rst_n), .fast_ce(fast_ce), .zero_fill(zero_fill),
        .head_slot(head_slot), .sample(sample),
        .dout(dout), .out_valid(out_valid), .head_flag(head_flag)
    );

    a_r1_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        fast_ce |=> out_valid);
    a_r1_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_ce |=> !out_valid);
    a_r3_zero_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ce && zero_fill && !slow_ce) |=> (head_flag || dout == '0));
    a_r2_repeat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ce && !zero_fill && !slow_ce) |=> (dout == $past(held)));
    a_r5_head_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ce && slow_ce) |=> (head_flag && dout == $past(din)));
    a_r7_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        head_flag |-> out_valid);
endmodule

// File: tb/upsamp_ce_bench.sv
module upsamp_ce_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int FAC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_ce = 1'b0, fast_ce = 1'b0, zero_fill = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic out_valid, head_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upsamp_ce #(.DATA_W(DW), .FACTOR(FAC)) u_upsamp_ce (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .fast_ce(fast_ce),
        .zero_fill(zero_fill), .din(din),
        .dout(dout), .out_valid(out_valid), .head_flag(head_flag)
    );

    // {slow, fast, zero_fill, din, exp_valid, exp_head, exp_dout}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 16'hA1A1, 1'b1, 1'b1, 16'hA1A1}, // R5 head w/ arrival
        {1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'hA1A1}, // R2 repeat
        {1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'hA1A1}, // R8 idle
        {1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 16'hA1A1}, // R2
        {1'b0, 1'b1, 1'b0, 16'h1234, 1'b1, 1'b0, 16'hA1A1}, // R4 last fill
        {1'b0, 1'b1, 1'b0, 16'h5555, 1'b1, 1'b1, 16'hA1A1}, // R4 wrap head
        {1'b1, 1'b1, 1'b1, 16'hB2B2, 1'b1, 1'b1, 16'hB2B2}, // R5 mid-frame realign
        {1'b0, 1'b1, 1'b1, 16'h7777, 1'b1, 1'b0, 16'h0000}, // R3 zero fill
        {1'b0, 1'b1, 1'b1, 16'h7777, 1'b1, 1'b0, 16'h0000}, // R3
        {1'b1, 1'b1, 1'b1, 16'hC3C3, 1'b1, 1'b1, 16'hC3C3}, // R5 early slow
        {1'b0, 1'b1, 1'b1, 16'h8888, 1'b1, 1'b0, 16'h0000}, // R3
        {1'b0, 1'b0, 1'b1, 16'h8888, 1'b0, 1'b0, 16'h0000}  // R8
    };

    task automatic check(input string req, input logic [DW-1:0] ed,
                         input logic ev, input logic eh);
        n_cmp++;
        if (dout !== ed || out_valid !== ev || head_flag !== eh) begin
            n_bad++;
            $display("FAIL %s: got dout=%h valid=%b head=%b, expected dout=%h valid=%b head=%b",
                     req, dout, out_valid, head_flag, ed, ev, eh);
        end
    endtask

    task automatic step(input logic s, input logic f, input logic z, input logic [DW-1:0] d);
        @(negedge clk);
        slow_ce = s; fast_ce = f; zero_fill = z; din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", '0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:18]);
            check($sformatf("vector %0d", i), VEC[i][15:0], VEC[i][17], VEC[i][16]);
        end

        // R6: lone slow enable captures and realigns
        step(1'b0, 1'b1, 1'b0, 16'h0);          // fill slot of C3C3 frame
        step(1'b1, 1'b0, 1'b0, 16'hD4D4);
        check("R6 no slot on lone slow", 16'hC3C3, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 16'h0);
        check("R6 head after lone slow", 16'hD4D4, 1'b1, 1'b1);

        // R4/R7: two frames with no new input, replicate mode
        for (int k = 1; k < 2 * FAC; k++) begin
            step(1'b0, 1'b1, 1'b0, 16'hEEEE);
            check("R4 R7 frame walk", 16'hD4D4, 1'b1, (k % FAC) == 0);
        end

        // R9: reset mid-frame, then first fast slot is head with zero
        step(1'b0, 1'b1, 1'b1, 16'h0);
        @(negedge clk); rst_n = 1'b0; fast_ce = 1'b0;
        @(posedge clk); #1;
        check("R9 reset mid-frame", '0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 16'h9999);
        check("R9 first slot head, held 0", '0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 16'h9999);
        check("R3 zero after reset head", '0, 1'b1, 1'b0);

        // R1: back-to-back idle gives no valid
        step(1'b0, 1'b0, 1'b1, 16'h0);
        check("R1 no pulse", '0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule